// File: doc/BRIEF.md
# Time Base Event Capture Unit

This block takes a snapshot of a free-running PWM time base counter and holds it for software. A snapshot is taken either on a software strobe or on a low-to-high transition of one of four hardware event lines: sync, feed-forward, current limit and fault. A 3-bit source code picks which event line, if any, may trigger.

Each snapshot stores the time base value present in the triggering cycle and raises a valid flag. The flag stays high until software clears it. A later snapshot replaces the stored value. Software reads the stored value and the flag directly from the outputs.

Top module: `tbase_capture`

## Requirements
- R1: After reset, `cap_data_o` is 0 and `cap_valid_o` is 0.
- R2: A high `sw_cap_i` in a cycle stores that cycle's `tbase_i` and sets `cap_valid_o` by the next clock edge, whatever the value of `src_sel_i`, including reserved codes.
- R3: With `src_sel_i` = 3'b000 no event line causes a capture. Only the software strobe can capture.
- R4: Source codes map as follows: 3'b001 = sync, 3'b010 = feed-forward, 3'b011 = current limit, 3'b100 = fault. Only the selected line can trigger a capture.
- R5: Source codes 3'b101, 3'b110 and 3'b111 never cause a hardware capture.
- R6: Event lines are edge-detected. A capture needs the line low in one cycle and high in the next. A line that stays high triggers nothing further. A line that is already high when reset is released is not treated as an edge.
- R7: A software strobe and a selected hardware edge in the same cycle produce one capture, which holds that cycle's `tbase_i`.
- R8: `cap_valid_o` stays high until `valid_clr_i` is pulsed. The clear drops the flag and leaves `cap_data_o` unchanged.
- R9: A capture while the flag is already high overwrites `cap_data_o` and keeps the flag high. If a capture and a clear fall in the same cycle, the capture wins.
- R10: Changing `src_sel_i` to a line that is already high does not cause a capture. Edges are tracked per line, independently of the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbase_i | input | 16 | Current time base count |
| evt_sync_i | input | 1 | Sync event line |
| evt_ffwd_i | input | 1 | Feed-forward event line |
| evt_ilim_i | input | 1 | Current-limit event line |
| evt_fault_i | input | 1 | Fault event line |
| src_sel_i | input | 3 | Hardware capture source code |
| sw_cap_i | input | 1 | Software capture strobe |
| valid_clr_i | input | 1 | Clear pulse for the valid flag |
| cap_data_o | output | 16 | Stored time base value |
| cap_valid_o | output | 1 | Capture-valid flag |

## Verification
For each source code, the bench raises every event line in turn with a distinct time base value. The stored value shows which line fired, and whether the selected one was the only line able to fire. Lines held high, lines already high at reset release, and lines that become selected while already high separate edge detection from level detection. Software strobes are applied alone, together with a hardware edge, and together with a clear. These cases separate the one-capture rule from the capture-beats-clear priority. They also show that clearing the flag leaves the stored value unchanged.

// File: rtl/tbcap_pkg.sv
package tbcap_pkg;
  localparam int unsigned EVT_N = 4;
  localparam int unsigned SEL_W = 3;

  // event line positions inside the internal event vector
  localparam int unsigned EV_SYNC  = 0;
  localparam int unsigned EV_FFWD  = 1;
  localparam int unsigned EV_ILIM  = 2;
  localparam int unsigned EV_FAULT = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_SW_ONLY = 3'd0,
    SRC_SYNC    = 3'd1,
    SRC_FFWD    = 3'd2,
    SRC_ILIM    = 3'd3,
    SRC_FAULT   = 3'd4
  } src_code_e;

  // decode a source code into a one-hot enable mask over the event lines;
  // software-only and reserved codes enable nothing
  function automatic logic [EVT_N-1:0] src_mask(input logic [SEL_W-1:0] code);
    logic [EVT_N-1:0] m;
    m = '0;
    case (code)
      SRC_SYNC:  m[EV_SYNC]  = 1'b1;
      SRC_FFWD:  m[EV_FFWD]  = 1'b1;
      SRC_ILIM:  m[EV_ILIM]  = 1'b1;
      SRC_FAULT: m[EV_FAULT] = 1'b1;
      default:   m = '0;
    endcase
    return m;
  endfunction

  function automatic logic code_reserved(input logic [SEL_W-1:0] code);
    return code > SRC_FAULT;
  endfunction
endpackage

// File: rtl/tcap_edge_detect.sv
module tcap_edge_detect #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    // previous level resets high so a line already high at reset release
    // is not seen as an edge
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[g] <= 1'b1;
      else        prev_q[g] <= level_i[g];
    end
    assign rise_o[g] = level_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/tcap_src_mux.sv
module tcap_src_mux
  import tbcap_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic [EVT_N-1:0] rise_i,
  input  logic [EVT_N-1:0] level_i,
  output logic [EVT_N-1:0] mask_o,
  output logic             hw_fire_o,
  output logic             sel_level_o
);
  always_comb begin
    mask_o      = src_mask(sel_i);
    hw_fire_o   = |(rise_i & mask_o);
    sel_level_o = |(level_i & mask_o);
  end
endmodule

// File: rtl/tcap_store.sv
module tcap_store #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire_i,
  input  logic         clr_i,
  input  logic [W-1:0] value_i,
  output logic [W-1:0] data_o,
  output logic         valid_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (fire_i) data_o <= value_i;
      // a capture in the same cycle as a clear keeps the flag set
      if (fire_i)     valid_o <= 1'b1;
      else if (clr_i) valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tbase_capture.sv
module tbase_capture
  import tbcap_pkg::*;
#(
  parameter int unsigned TB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TB_W-1:0] tbase_i,
  input  logic            evt_sync_i,
  input  logic            evt_ffwd_i,
  input  logic            evt_ilim_i,
  input  logic            evt_fault_i,
  input  logic [2:0]      src_sel_i,
  input  logic            sw_cap_i,
  input  logic            valid_clr_i,
  output logic [TB_W-1:0] cap_data_o,
  output logic            cap_valid_o
);
  logic [EVT_N-1:0] evt_level;
  logic [EVT_N-1:0] evt_rise;
  logic [EVT_N-1:0] sel_mask;
  logic             hw_fire;
  logic             sel_level;
  logic             capture_fire;

  always_comb begin
    evt_level           = '0;
    evt_level[EV_SYNC]  = evt_sync_i;
    evt_level[EV_FFWD]  = evt_ffwd_i;
    evt_level[EV_ILIM]  = evt_ilim_i;
    evt_level[EV_FAULT] = evt_fault_i;
  end

  tcap_edge_detect #(.N(EVT_N)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (evt_level),
    .rise_o  (evt_rise)
  );

  tcap_src_mux u_mux (
    .sel_i       (src_sel_i),
    .rise_i      (evt_rise),
    .level_i     (evt_level),
    .mask_o      (sel_mask),
    .hw_fire_o   (hw_fire),
    .sel_level_o (sel_level)
  );

  assign capture_fire = sw_cap_i | hw_fire;

  tcap_store #(.W(TB_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (capture_fire),
    .clr_i   (valid_clr_i),
    .value_i (tbase_i),
    .data_o  (cap_data_o),
    .valid_o (cap_valid_o)
  );
endmodule

// File: rtl/tbase_capture_chk.sv
module tbase_capture_chk
  import tbcap_pkg::*;
#(
  parameter int unsigned TB_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TB_W-1:0]  tbase_i,
  input logic [2:0]       src_sel_i,
  input logic             sw_cap_i,
  input logic             valid_clr_i,
  input logic [TB_W-1:0]  cap_data_o,
  input logic             cap_valid_o,
  input logic [EVT_N-1:0] sel_mask,
  input logic             hw_fire,
  input logic             sel_level,
  input logic             capture_fire
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (cap_data_o == '0) && !cap_valid_o);

  p_sw_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_cap_i |=> cap_valid_o && (cap_data_o == $past(tbase_i)));

  p_sw_only_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_i == 3'd0) && !sw_cap_i |=> $stable(cap_data_o));

  p_mask_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_mask));

  p_reserved_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_i > 3'd4) && !sw_cap_i |=> $stable(cap_data_o));

  p_edge_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_fire |-> sel_level);

  p_single_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_cap_i && hw_fire |=> cap_data_o == $past(tbase_i));

  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid_o && !valid_clr_i |=> cap_valid_o);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_clr_i && !capture_fire |=> !cap_valid_o && $stable(cap_data_o));

  p_capture_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    capture_fire |=> cap_valid_o && (cap_data_o == $past(tbase_i)));
endmodule

bind tbase_capture tbase_capture_chk #(.TB_W(TB_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tbase_i      (tbase_i),
  .src_sel_i    (src_sel_i),
  .sw_cap_i     (sw_cap_i),
  .valid_clr_i  (valid_clr_i),
  .cap_data_o   (cap_data_o),
  .cap_valid_o  (cap_valid_o),
  .sel_mask     (sel_mask),
  .hw_fire      (hw_fire),
  .sel_level    (sel_level),
  .capture_fire (capture_fire)
);

// File: tb/tb_tbase_capture.sv
`timescale 1ns/1ps
module tb_tbase_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] tbase;
  logic [3:0]  evts;   // [0]=sync [1]=ffwd [2]=ilim [3]=fault
  logic [2:0]  sel;
  logic        sw, clr;
  logic [15:0] cap_data;
  logic        cap_valid;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tbase_capture dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tbase_i     (tbase),
    .evt_sync_i  (evts[0]),
    .evt_ffwd_i  (evts[1]),
    .evt_ilim_i  (evts[2]),
    .evt_fault_i (evts[3]),
    .src_sel_i   (sel),
    .sw_cap_i    (sw),
    .valid_clr_i (clr),
    .cap_data_o  (cap_data),
    .cap_valid_o (cap_valid)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply inputs for one cycle; return 1 ns after the edge
  task automatic cyc(input logic [15:0] t, input logic [3:0] e, input logic [2:0] s,
                     input logic w, input logic c);
    tbase = t; evts = e; sel = s; sw = w; clr = c;
    @(posedge clk); #1;
    sw = 1'b0; clr = 1'b0;
  endtask

  task automatic do_reset(input logic [3:0] e);
    rst_n = 1'b0; tbase = '0; evts = e; sel = 3'd0; sw = 1'b0; clr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset(4'b0000);
    check(cap_data == 16'h0, "R1 data", cap_data, 0);
    check(cap_valid == 1'b0, "R1 valid", cap_valid, 0);
  endtask

  task automatic t_software;
    cyc(16'h1234, 4'b0, 3'd0, 1'b1, 1'b0);
    check(cap_data == 16'h1234, "R2 sw data", cap_data, 16'h1234);
    check(cap_valid, "R2 sw valid", cap_valid, 1);
    cyc(16'h0BAD, 4'b0, 3'd6, 1'b1, 1'b0);
    check(cap_data == 16'h0BAD, "R2 sw with reserved code", cap_data, 16'h0BAD);
  endtask

  task automatic t_clear;
    cyc(16'h1111, 4'b0, 3'd0, 1'b0, 1'b0);
    check(cap_valid, "R8 flag sticky", cap_valid, 1);
    cyc(16'h2222, 4'b0, 3'd0, 1'b0, 1'b1);
    check(!cap_valid, "R8 clear", cap_valid, 0);
    check(cap_data == 16'h0BAD, "R8 data kept", cap_data, 16'h0BAD);
  endtask

  task automatic t_sw_only_code;
    for (int i = 0; i < 4; i++) begin
      cyc(16'h3000 + 16'(i), 4'b0, 3'd0, 1'b0, 1'b0);
      cyc(16'h3100 + 16'(i), 4'(1 << i), 3'd0, 1'b0, 1'b0);
      check(cap_data == 16'h0BAD && !cap_valid, "R3 no hw capture", cap_data, 16'h0BAD);
    end
    cyc(16'h0, 4'b0, 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_mapping;
    for (int code = 1; code <= 4; code++) begin
      cyc(16'h0, 4'b0, 3'(code), 1'b0, 1'b1);
      for (int ln = 0; ln < 4; ln++) begin
        if (ln != code - 1) begin
          cyc(16'h4000, 4'(1 << ln), 3'(code), 1'b0, 1'b0);
          cyc(16'h4001, 4'b0, 3'(code), 1'b0, 1'b0);
        end
      end
      check(!cap_valid, "R4 other lines ignored", cap_valid, 0);
      cyc(16'h5000 + 16'(code), 4'(1 << (code - 1)), 3'(code), 1'b0, 1'b0);
      check(cap_valid && cap_data == 16'h5000 + 16'(code), "R4 selected line captures",
            cap_data, 16'h5000 + code);
      cyc(16'h0, 4'b0, 3'(code), 1'b0, 1'b0);
    end
  endtask

  task automatic t_reserved;
    cyc(16'h0, 4'b0, 3'd5, 1'b0, 1'b1);
    for (int code = 5; code <= 7; code++) begin
      cyc(16'h6000, 4'b1111, 3'(code), 1'b0, 1'b0);
      cyc(16'h6001, 4'b0000, 3'(code), 1'b0, 1'b0);
      check(!cap_valid && cap_data == 16'h5004, "R5 reserved code quiet", cap_data, 16'h5004);
    end
  endtask

  task automatic t_edge;
    cyc(16'h0, 4'b0, 3'd1, 1'b0, 1'b1);
    cyc(16'h7001, 4'b0001, 3'd1, 1'b0, 1'b0);
    cyc(16'h7002, 4'b0001, 3'd1, 1'b0, 1'b0);
    cyc(16'h7003, 4'b0001, 3'd1, 1'b0, 1'b0);
    check(cap_data == 16'h7001, "R6 held high no recapture", cap_data, 16'h7001);
    cyc(16'h7004, 4'b0000, 3'd1, 1'b0, 1'b0);
    cyc(16'h7005, 4'b0001, 3'd1, 1'b0, 1'b0);
    check(cap_data == 16'h7005, "R6 new edge captures", cap_data, 16'h7005);
    cyc(16'h0, 4'b0, 3'd1, 1'b0, 1'b0);
  endtask

  task automatic t_high_at_reset;
    do_reset(4'b1000);
    cyc(16'h8001, 4'b1000, 3'd4, 1'b0, 1'b0);
    cyc(16'h8002, 4'b1000, 3'd4, 1'b0, 1'b0);
    check(!cap_valid && cap_data == 16'h0, "R6 high at reset no edge", cap_data, 0);
    cyc(16'h8003, 4'b0000, 3'd4, 1'b0, 1'b0);
  endtask

  task automatic t_both;
    cyc(16'h9009, 4'b0001, 3'd1, 1'b1, 1'b0);
    check(cap_valid && cap_data == 16'h9009, "R7 one capture of that cycle", cap_data, 16'h9009);
    cyc(16'h900A, 4'b0001, 3'd1, 1'b0, 1'b0);
    check(cap_data == 16'h9009, "R7 no second capture", cap_data, 16'h9009);
    cyc(16'h0, 4'b0, 3'd1, 1'b0, 1'b0);
  endtask

  task automatic t_overwrite;
    cyc(16'hA0A0, 4'b0, 3'd0, 1'b1, 1'b0);
    check(cap_valid && cap_data == 16'hA0A0, "R9 overwrite keeps flag", cap_data, 16'hA0A0);
    cyc(16'hA1A1, 4'b0, 3'd0, 1'b1, 1'b1);
    check(cap_valid, "R9 capture beats clear", cap_valid, 1);
    check(cap_data == 16'hA1A1, "R9 capture with clear data", cap_data, 16'hA1A1);
  endtask

  task automatic t_sel_switch;
    cyc(16'h0, 4'b0, 3'd1, 1'b0, 1'b1);
    cyc(16'hB001, 4'b0100, 3'd1, 1'b0, 1'b0);
    cyc(16'hB002, 4'b0100, 3'd3, 1'b0, 1'b0);
    cyc(16'hB003, 4'b0100, 3'd3, 1'b0, 1'b0);
    check(!cap_valid && cap_data == 16'hA1A1, "R10 switch onto high line", cap_data, 16'hA1A1);
    cyc(16'hB004, 4'b0000, 3'd3, 1'b0, 1'b0);
    cyc(16'hB005, 4'b0100, 3'd3, 1'b0, 1'b0);
    check(cap_valid && cap_data == 16'hB005, "R10 later edge captures", cap_data, 16'hB005);
  endtask

  initial begin
    t_reset();
    t_software();
    t_clear();
    t_sw_only_code();
    t_mapping();
    t_reserved();
    t_edge();
    t_both();
    t_overwrite();
    t_sel_switch();
    t_high_at_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule